// File: doc/BRIEF.md
# Zero-Substitution Bipolar Line Coder

This block is the transmit-side line coder of a coaxial DS3, STS-1 or E3 interface. It runs on one transmit clock. In binary mode it takes one NRZ bit per clock and drives a pulse pair (positive, negative) with alternate mark inversion. Runs of zeros are replaced by substitution codes that hold ones density on the line. DS3 and STS-1 use three-zero substitution (B3ZS). E3 uses four-zero substitution (HDB3). In bipolar mode the coder is bypassed and an already-coded pulse pair is forwarded.

Inputs can be sampled on either clock edge. An internal pattern source can replace the data with all ones or a repeating 1,0,0 sequence. An output enable forces both outputs low, so an upstream power-down or driver-disable simply drives the enable low. The zero-substitution decision needs lookahead, so every path has the same fixed latency.

Top module: `zs_line_coder`

## Requirements
- R1: While rst_ni is low, and until the first coded pulse leaves the pipeline after release, line_pos_o and line_neg_o are 0.
- R2: An input sampled at rising edge E appears on the outputs right after rising edge E+4, in binary mode and in bypass alike.
- R3: With bin_mode_i=0 and no pattern selected, line_pos_o follows tx_pos_i and line_neg_o follows tx_neg_i. An input pair with both bits 1 is sent as idle (both 0).
- R4: With bin_mode_i=1, tx_neg_i has no effect on the outputs; data comes only from tx_data_i.
- R5: In binary mode each 1 is a pulse of polarity opposite to the previous pulse. After reset the first pulse is positive.
- R6: For line_type_i 00 (DS3) or 01 (STS-1), every run of three zeros becomes 00V when an odd number of marks has been sent since the last substitution, else B0V. The count is even after reset. V repeats the previous pulse polarity; B alternates.
- R7: For line_type_i 10 (E3), every run of four zeros becomes 000V (odd count) or B00V (even count), with the same counting and V/B rules as R6.
- R8: With clk_inv_i=0, inputs are taken at the rising edge. With clk_inv_i=1 they are taken at the preceding falling edge and enter the same pipeline at the next rising edge.
- R9: pat_sel_i 01 replaces the data with all ones. pat_sel_i 10 replaces it with 1,0,0 repeating, starting with 1 at the first sampled edge. Either pattern is line coded even when bin_mode_i=0. Codes 00 and 11 use the inputs.
- R10: When out_en_i is low at a rising edge, both outputs are 0 after that edge. The coder state keeps advancing meanwhile.
- R11: line_pos_o and line_neg_o are never both 1.
- R12: A change of line_type_i clears the mark-count parity and the polarity state, so the next pulse is positive and the next substitution counts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_type_i | input | 2 | 00 DS3, 01 STS-1, 10 E3, 11 treated as B3ZS |
| bin_mode_i | input | 1 | 1 binary with coding, 0 bipolar bypass |
| clk_inv_i | input | 1 | 1 samples inputs on the falling edge |
| pat_sel_i | input | 2 | 00/11 data, 01 all ones, 10 repeating 1,0,0 |
| tx_data_i | input | 1 | NRZ data in binary mode |
| tx_pos_i | input | 1 | Positive pulse request in bypass |
| tx_neg_i | input | 1 | Negative pulse request in bypass |
| out_en_i | input | 1 | Output enable; low forces idle |
| line_pos_o | output | 1 | Positive pulse to the line driver |
| line_neg_o | output | 1 | Negative pulse to the line driver |

## Verification
The properties assume control inputs change only between clock edges and hold steady for several cycles when a coding run is judged. The zero-run bounds are checked only after line type, mode, pattern, edge select and enable have held for six edges. The bypass property applies only when the sample edge four cycles back saw bypass, no pattern and rising-edge sampling. The bench drives every input two nanoseconds after a rising edge, apart from the deliberate mid-cycle change used to tell the two sampling edges apart. Each scenario starts from reset with the line in bypass, so the lookahead window never holds coded zeros from an earlier run. The one exception is the line-change scenario, which keeps state on purpose.

// File: rtl/zs_pkg.sv
package zs_pkg;
  typedef enum logic [1:0] {
    SYM_NONE = 2'd0,
    SYM_MARK = 2'd1,
    SYM_BPL  = 2'd2,
    SYM_VIOL = 2'd3
  } sym_e;

  typedef struct packed {
    logic coded;
    sym_e sym;
    logic raw_p;
    logic raw_n;
  } slot_t;

  localparam logic [1:0] LT_DS3  = 2'd0;
  localparam logic [1:0] LT_STS1 = 2'd1;
  localparam logic [1:0] LT_E3   = 2'd2;

  localparam logic [1:0] PAT_NONE = 2'd0;
  localparam logic [1:0] PAT_ONES = 2'd1;
  localparam logic [1:0] PAT_TRIO = 2'd2;
endpackage

// File: rtl/zs_sampler.sv
module zs_sampler
  import zs_pkg::*;
#(
  parameter int PAT_PERIOD = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clk_inv_i,
  input  logic       bin_mode_i,
  input  logic [1:0] pat_sel_i,
  input  logic       tx_data_i,
  input  logic       tx_pos_i,
  input  logic       tx_neg_i,
  output slot_t      slot_o
);
  localparam int PH_W = (PAT_PERIOD > 1) ? $clog2(PAT_PERIOD) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PAT_PERIOD - 1);

  logic       fd_q, fp_q, fn_q;
  logic [PH_W-1:0] ph_q;
  logic       d_s, p_s, n_s, pat_on, bit_s, coded_s;
  slot_t      slot_q;

  // falling-edge capture for inverted sampling
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fd_q <= 1'b0;
      fp_q <= 1'b0;
      fn_q <= 1'b0;
    end else begin
      fd_q <= tx_data_i;
      fp_q <= tx_pos_i;
      fn_q <= tx_neg_i;
    end
  end

  always_comb begin
    d_s     = clk_inv_i ? fd_q : tx_data_i;
    p_s     = clk_inv_i ? fp_q : tx_pos_i;
    n_s     = clk_inv_i ? fn_q : tx_neg_i;
    pat_on  = (pat_sel_i == PAT_ONES) || (pat_sel_i == PAT_TRIO);
    coded_s = bin_mode_i || pat_on;
    unique case (pat_sel_i)
      PAT_ONES: bit_s = 1'b1;
      PAT_TRIO: bit_s = (ph_q == '0);
      default:  bit_s = d_s;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0;
    end else if (pat_sel_i == PAT_TRIO) begin
      ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    end else begin
      ph_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
    end else begin
      slot_q.coded <= coded_s;
      slot_q.sym   <= (coded_s && bit_s) ? SYM_MARK : SYM_NONE;
      slot_q.raw_p <= coded_s ? 1'b0 : p_s;
      slot_q.raw_n <= coded_s ? 1'b0 : n_s;
    end
  end

  assign slot_o = slot_q;
endmodule

// File: rtl/zs_subst.sv
module zs_subst
  import zs_pkg::*;
#(
  parameter int SHORT_RUN = 3,
  parameter int LONG_RUN  = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  long_run_i,
  input  logic  clr_i,
  input  slot_t slot_i,
  output slot_t slot_o
);
  localparam int DEPTH = LONG_RUN - 1;

  slot_t w_q  [DEPTH];
  slot_t cand [DEPTH+1];
  slot_t nxt  [DEPTH+1];
  logic [DEPTH:0] plain;
  logic par_q, sub_hit;

  always_comb begin
    cand[0] = slot_i;
    for (int k = 0; k < DEPTH; k++) cand[k+1] = w_q[k];
  end

  // a plain zero is a coded slot without a pulse
  for (genvar g = 0; g <= DEPTH; g++) begin : g_plain
    assign plain[g] = cand[g].coded && (cand[g].sym == SYM_NONE);
  end

  assign sub_hit = long_run_i ? (&plain[LONG_RUN-1:0]) : (&plain[SHORT_RUN-1:0]);

  always_comb begin
    for (int k = 0; k <= DEPTH; k++) nxt[k] = cand[k];
    if (sub_hit) begin
      nxt[0].sym = SYM_VIOL;
      if (!par_q) begin
        if (long_run_i) nxt[LONG_RUN-1].sym = SYM_BPL;
        else            nxt[SHORT_RUN-1].sym = SYM_BPL;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) w_q[g] <= '0;
      else         w_q[g] <= nxt[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        par_q <= 1'b0;
    else if (clr_i || sub_hit)                          par_q <= 1'b0;
    else if (slot_i.coded && slot_i.sym == SYM_MARK)    par_q <= ~par_q;
  end

  assign slot_o = nxt[DEPTH];
endmodule

// File: rtl/zs_polarity.sv
module zs_polarity
  import zs_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  out_en_i,
  input  slot_t slot_i,
  output logic  pos_o,
  output logic  neg_o
);
  logic last_neg_q, pulse, neg_pol, p_nxt, n_nxt;
  logic pos_q, neg_q;

  always_comb begin
    pulse   = slot_i.coded && (slot_i.sym != SYM_NONE);
    // violation repeats the last polarity, others alternate
    neg_pol = (slot_i.sym == SYM_VIOL) ? last_neg_q : ~last_neg_q;
    if (slot_i.coded) begin
      p_nxt = pulse && !neg_pol;
      n_nxt = pulse && neg_pol;
    end else begin
      p_nxt = slot_i.raw_p && !slot_i.raw_n;
      n_nxt = slot_i.raw_n && !slot_i.raw_p;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_neg_q <= 1'b1;
      pos_q      <= 1'b0;
      neg_q      <= 1'b0;
    end else begin
      if (clr_i)      last_neg_q <= 1'b1;
      else if (pulse) last_neg_q <= neg_pol;
      pos_q <= out_en_i && p_nxt;
      neg_q <= out_en_i && n_nxt;
    end
  end

  assign pos_o = pos_q;
  assign neg_o = neg_q;
endmodule

// File: rtl/zs_line_coder.sv
module zs_line_coder
  import zs_pkg::*;
#(
  parameter int PAT_PERIOD = 3,
  parameter int SHORT_RUN  = 3,
  parameter int LONG_RUN   = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] line_type_i,
  input  logic       bin_mode_i,
  input  logic       clk_inv_i,
  input  logic [1:0] pat_sel_i,
  input  logic       tx_data_i,
  input  logic       tx_pos_i,
  input  logic       tx_neg_i,
  input  logic       out_en_i,
  output logic       line_pos_o,
  output logic       line_neg_o
);
  logic [1:0] lt_q;
  logic       lt_chg, hdb3;
  slot_t      s_slot, o_slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lt_q <= LT_DS3;
    else         lt_q <= line_type_i;
  end

  assign lt_chg = (line_type_i != lt_q);
  assign hdb3   = (line_type_i == LT_E3);

  zs_sampler #(.PAT_PERIOD(PAT_PERIOD)) u_smp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clk_inv_i  (clk_inv_i),
    .bin_mode_i (bin_mode_i),
    .pat_sel_i  (pat_sel_i),
    .tx_data_i  (tx_data_i),
    .tx_pos_i   (tx_pos_i),
    .tx_neg_i   (tx_neg_i),
    .slot_o     (s_slot)
  );

  zs_subst #(.SHORT_RUN(SHORT_RUN), .LONG_RUN(LONG_RUN)) u_sub (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .long_run_i (hdb3),
    .clr_i      (lt_chg),
    .slot_i     (s_slot),
    .slot_o     (o_slot)
  );

  zs_polarity u_pol (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (lt_chg),
    .out_en_i (out_en_i),
    .slot_i   (o_slot),
    .pos_o    (line_pos_o),
    .neg_o    (line_neg_o)
  );
endmodule

// File: rtl/zs_line_coder_chk.sv
module zs_line_coder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] line_type_i,
  input logic       bin_mode_i,
  input logic       clk_inv_i,
  input logic [1:0] pat_sel_i,
  input logic       tx_pos_i,
  input logic       tx_neg_i,
  input logic       out_en_i,
  input logic       line_pos_o,
  input logic       line_neg_o
);
  logic [2:0] age_q, st_q, zr_q;
  logic [5:0] cfg_q, cfg_now;
  logic       coded_cfg;

  assign cfg_now   = {line_type_i, bin_mode_i, clk_inv_i, pat_sel_i};
  assign coded_cfg = bin_mode_i || (pat_sel_i == 2'd1) || (pat_sel_i == 2'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q <= '0;
      st_q  <= '0;
      zr_q  <= '0;
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_now;
      if (age_q != 3'd7) age_q <= age_q + 3'd1;
      if (coded_cfg && out_en_i && cfg_now == cfg_q) begin
        if (st_q != 3'd7) st_q <= st_q + 3'd1;
      end else begin
        st_q <= '0;
      end
      if (st_q >= 3'd6) begin
        if (line_pos_o || line_neg_o) zr_q <= '0;
        else if (zr_q != 3'd7)        zr_q <= zr_q + 3'd1;
      end else begin
        zr_q <= '0;
      end
    end
  end

  p_never_both_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(line_pos_o && line_neg_o));

  p_disable_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |=> (!line_pos_o && !line_neg_o));

  // also covers R2: bypass pair shows up after a fixed four-stage delay
  p_bypass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 3'd6 && $past(out_en_i) &&
     $past(!bin_mode_i && !clk_inv_i && pat_sel_i != 2'd1 && pat_sel_i != 2'd2, 5))
    |-> (line_pos_o == $past(tx_pos_i && !tx_neg_i, 5)) &&
        (line_neg_o == $past(tx_neg_i && !tx_pos_i, 5)));

  p_short_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q >= 3'd6 && cfg_q[5:4] != 2'd2) |-> (zr_q <= 3'd2));

  p_long_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q >= 3'd6 && cfg_q[5:4] == 2'd2) |-> (zr_q <= 3'd3));
endmodule

bind zs_line_coder zs_line_coder_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .line_type_i (line_type_i),
  .bin_mode_i  (bin_mode_i),
  .clk_inv_i   (clk_inv_i),
  .pat_sel_i   (pat_sel_i),
  .tx_pos_i    (tx_pos_i),
  .tx_neg_i    (tx_neg_i),
  .out_en_i    (out_en_i),
  .line_pos_o  (line_pos_o),
  .line_neg_o  (line_neg_o)
);

// File: tb/sim_zs_line_coder.sv
`timescale 1ns/1ps
module sim_zs_line_coder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] line_type = 2'd0, pat_sel = 2'd0;
  logic bin_mode = 1'b0, clk_inv = 1'b0, tx_data = 1'b0, tx_pos = 1'b0, tx_neg = 1'b0, out_en = 1'b1;
  logic line_pos, line_neg;

  always #10 clk = ~clk;

  zs_line_coder u0 (
    .clk_i(clk), .rst_ni(rst_n), .line_type_i(line_type), .bin_mode_i(bin_mode),
    .clk_inv_i(clk_inv), .pat_sel_i(pat_sel), .tx_data_i(tx_data), .tx_pos_i(tx_pos),
    .tx_neg_i(tx_neg), .out_en_i(out_en), .line_pos_o(line_pos), .line_neg_o(line_neg)
  );

  int checks = 0, errors = 0;
  logic a_d[64], a_p[64], a_n[64], a_oe[64], a_bin[64], a_late[64], a_latep[64];
  logic [1:0] a_line[64];
  logic [1:0] cfg_pat;
  logic cfg_inv;
  logic o_p[64], o_n[64], e_p[64], e_n[64];

  task automatic chk(input string req, input int idx, input logic ap, input logic an,
                     input logic xp, input logic xn);
    checks++;
    if (ap !== xp || an !== xn) begin
      errors++;
      $display("FAIL %s idx %0d actual p=%b n=%b expected p=%b n=%b", req, idx, ap, an, xp, xn);
    end
  endtask

  task automatic prep(input logic bin, input logic [1:0] lt);
    for (int i = 0; i < 64; i++) begin
      a_d[i] = 0; a_p[i] = 0; a_n[i] = 0; a_oe[i] = 1; a_bin[i] = bin;
      a_late[i] = 0; a_latep[i] = 0; a_line[i] = lt; e_p[i] = 0; e_n[i] = 0;
    end
    cfg_pat = 2'd0;
    cfg_inv = 1'b0;
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst_n = 0; bin_mode = 0; line_type = 0; pat_sel = 0; clk_inv = 0;
    tx_data = 0; tx_pos = 0; tx_neg = 0; out_en = 1;
    repeat (2) @(posedge clk);
    #2 rst_n = 1;
  endtask

  task automatic run(input int len);
    int both = 0;
    for (int c = 0; c < len; c++) begin
      @(posedge clk); #2;
      tx_data = a_d[c]; tx_pos = a_p[c]; tx_neg = a_n[c]; out_en = a_oe[c];
      bin_mode = a_bin[c]; line_type = a_line[c]; pat_sel = cfg_pat; clk_inv = cfg_inv;
      @(negedge clk);
      o_p[c] = line_pos; o_n[c] = line_neg;
      if (line_pos && line_neg) both++;
      if (a_late[c]) begin #2 tx_pos = a_latep[c]; end
    end
    checks++;
    if (both != 0) begin
      errors++;
      $display("FAIL R11 both outputs high in %0d cycles, expected 0", both);
    end
  endtask

  // independent reference: greedy zero-run substitution over the whole sequence
  task automatic model(input int len, input int k);
    int sym[64];
    logic src[64];
    int par = 0, i = 0;
    logic lneg = 1'b1;
    for (int j = 0; j < len; j++)
      src[j] = (cfg_pat == 2'd1) ? 1'b1 : (cfg_pat == 2'd2) ? (j % 3 == 0) : a_d[j];
    while (i < len) begin
      if (src[i]) begin
        sym[i] = 1; par ^= 1; i++;
      end else begin
        logic allz;
        allz = (i + k <= len);
        for (int j = 0; j < k && i + j < len; j++) if (src[i+j]) allz = 0;
        if (allz) begin
          for (int j = 0; j < k; j++) sym[i+j] = 0;
          sym[i+k-1] = 2;
          if (par == 0) sym[i] = 1;
          par = 0; i += k;
        end else begin
          sym[i] = 0; i++;
        end
      end
    end
    for (int j = 0; j < len; j++) begin
      if (sym[j] == 1) begin e_p[j] = lneg; e_n[j] = ~lneg; lneg = ~lneg; end
      else if (sym[j] == 2) begin e_p[j] = ~lneg; e_n[j] = lneg; end
      else begin e_p[j] = 0; e_n[j] = 0; end
    end
  endtask

  task automatic cmp(input string req, input int n);
    for (int i = 0; i < n; i++)
      chk(req, i, o_p[i+5], o_n[i+5], e_p[i] & a_oe[i+4], e_n[i] & a_oe[i+4]);
  endtask

  task automatic t_reset();  // R1
    @(posedge clk); #2 rst_n = 0; tx_pos = 1; bin_mode = 0;
    @(negedge clk);
    chk("R1 in reset", 0, line_pos, line_neg, 1'b0, 1'b0);
    do_reset();
    @(negedge clk);
    chk("R1 after release", 1, line_pos, line_neg, 1'b0, 1'b0);
  endtask

  task automatic t_latency();  // R2
    do_reset(); prep(1'b0, 2'd0);
    a_p[0] = 1; run(8);
    chk("R2 early", 4, o_p[4], o_n[4], 1'b0, 1'b0);
    chk("R2 on time", 5, o_p[5], o_n[5], 1'b1, 1'b0);
    chk("R2 single", 6, o_p[6], o_n[6], 1'b0, 1'b0);
  endtask

  task automatic t_ami();  // R5
    do_reset(); prep(1'b1, 2'd0);
    a_d[0] = 1; a_d[1] = 1; a_d[3] = 1; a_d[4] = 1; a_d[5] = 1;
    run(12); model(12, 3);
    chk("R5 first positive", 0, o_p[5], o_n[5], 1'b1, 1'b0);
    cmp("R5", 6);
  endtask

  task automatic t_b3zs();  // R6
    do_reset(); prep(1'b1, 2'd0);
    a_d[0] = 1; a_d[4] = 1; a_d[5] = 1;
    run(18); model(18, 3); cmp("R6 ds3", 12);
    do_reset(); prep(1'b1, 2'd1);
    a_d[3] = 1; a_d[5] = 1;
    run(16); model(16, 3); cmp("R6 sts1", 10);
  endtask

  task automatic t_hdb3();  // R7
    do_reset(); prep(1'b1, 2'd2);
    a_d[0] = 1; a_d[5] = 1; a_d[6] = 1; a_d[15] = 1;
    run(22); model(22, 4); cmp("R7 mixed", 16);
    do_reset(); prep(1'b1, 2'd2);
    run(14); model(14, 4); cmp("R7 zeros", 8);
  endtask

  task automatic t_bypass();  // R3
    do_reset(); prep(1'b0, 2'd0);
    a_p[0] = 1; a_n[1] = 1; a_p[2] = 1; a_n[2] = 1; a_n[4] = 1; a_p[5] = 1;
    for (int i = 0; i < 6; i++) a_d[i] = 1;
    run(12);
    for (int i = 0; i < 6; i++) begin e_p[i] = a_p[i] & ~a_n[i]; e_n[i] = a_n[i] & ~a_p[i]; end
    cmp("R3", 6);
  endtask

  task automatic t_neg_ignored();  // R4
    do_reset(); prep(1'b1, 2'd2);
    a_d[0] = 1; a_d[2] = 1; a_d[7] = 1;
    for (int i = 0; i < 14; i++) a_n[i] = (i % 2 == 0);
    run(14); model(14, 4); cmp("R4", 8);
  endtask

  task automatic t_clkinv();  // R8
    do_reset(); prep(1'b0, 2'd0); cfg_inv = 1;
    a_p[0] = 1; a_late[0] = 1; a_latep[0] = 0;
    run(8); chk("R8 inv early value", 5, o_p[5], o_n[5], 1'b1, 1'b0);
    do_reset(); prep(1'b0, 2'd0);
    a_p[0] = 1; a_late[0] = 1; a_latep[0] = 0;
    run(8); chk("R8 rise late value", 5, o_p[5], o_n[5], 1'b0, 1'b0);
    do_reset(); prep(1'b0, 2'd0); cfg_inv = 1;
    a_late[0] = 1; a_latep[0] = 1;
    run(8); chk("R8 inv ignores late", 5, o_p[5], o_n[5], 1'b0, 1'b0);
    do_reset(); prep(1'b0, 2'd0);
    a_late[0] = 1; a_latep[0] = 1;
    run(8); chk("R8 rise takes late", 5, o_p[5], o_n[5], 1'b1, 1'b0);
  endtask

  task automatic t_pattern();  // R9
    do_reset(); prep(1'b0, 2'd0); cfg_pat = 2'd1;
    run(14); model(14, 3); cmp("R9 ones", 8);
    do_reset(); prep(1'b0, 2'd2); cfg_pat = 2'd2;
    for (int i = 0; i < 20; i++) a_d[i] = (i % 4 == 1);
    run(20); model(20, 4); cmp("R9 trio", 12);
    do_reset(); prep(1'b1, 2'd0); cfg_pat = 2'd3;
    a_d[1] = 1; a_d[2] = 1; a_d[6] = 1;
    run(14); model(14, 3); cmp("R9 code11 data", 8);
  endtask

  task automatic t_enable();  // R10
    do_reset(); prep(1'b1, 2'd0); cfg_pat = 2'd1;
    a_oe[6] = 0; a_oe[7] = 0; a_oe[8] = 0;
    run(18); model(18, 3); cmp("R10", 12);
  endtask

  task automatic t_line_change();  // R12
    do_reset(); prep(1'b1, 2'd0);
    for (int i = 1; i <= 6; i++) a_bin[i] = 0;
    for (int i = 5; i < 64; i++) a_line[i] = 2'd1;
    a_d[0] = 1; a_d[7] = 1;
    run(17);
    e_p[0] = 1; e_p[7] = 1; e_p[10] = 1;
    cmp("R12", 11);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_ami();
    t_b3zs();
    t_hdb3();
    t_bypass();
    t_neg_ignored();
    t_clkinv();
    t_pattern();
    t_enable();
    t_line_change();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule